// File: doc/BRIEF.md
# Elastic Transmit Phase Buffer

This block sits on the transmit path between a 4-bit parallel data stream, clocked by a source clock from outside the chip, and the internally generated reference clock that feeds the parallel-to-serial stage. The two clocks run at the same frequency, but their phase relation is not known and may wander. The buffer holds nine 4-bit words, so the phase can move by a few word times before anything is lost.

The write side stores one word on every source clock edge. The read side removes one word on every reference clock edge. Each side tracks its position with a pointer, and each pointer reaches the other clock domain as a Gray-coded value through a chain of synchroniser flops. When the two pointers come too close in either direction, the block raises a sticky `overflow` flag. Recovery is called recentring. It moves the read pointer to about half the depth behind the write pointer and drives zeros on the read data while it runs. Recentring starts when the `fifoRst` input is high. It also starts on its own when `autoRst` is high and the flag is set.

Top module: `elastic_tx_fifo`

## Requirements
- R1: Outside recentring and overflow, every word written on `wrClk` appears on `rdData` exactly once and in the order written. With the bench's counting pattern, each `rdData` value is the previous value plus one, modulo 16.
- R2: If the write clock is held for one period and then resumes at the same phase, `overflow` stays low and the read sequence has no break.
- R3: If the write clock is held for eight periods (read underrun), or runs twice as fast for twenty edges (write overrun), `overflow` goes high (1 = collision).
- R4: With `autoRst` low, a set `overflow` stays high until a recentring completes.
- R5: With `autoRst` high, a set `overflow` starts recentring without any other input. Within 60 `rdClk` cycles `overflow` is low again and the read sequence is contiguous.
- R6: `fifoRst` high, seen through a two-flop synchroniser on `rdClk`, holds the block in recentring for as long as it stays high. Recentring ends SETTLE (8) `rdClk` cycles after `fifoRst` is seen low, and `overflow` is low when it ends.
- R7: `rdData` is 0 for the whole of a recentring. After reset, `overflow` is 0 and `rdData` is 0.
- R8: After recentring, the word on `rdData` trails the word on `wrData` by 2 to 7 positions in the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Source clock of the incoming parallel data |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrData | input | 4 | Parallel word stored on each `wrClk` rising edge |
| rdClk | input | 1 | Internal transmit reference clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| fifoRst | input | 1 | Manual recentring request, active high, asynchronous to `rdClk` |
| autoRst | input | 1 | 1 = start recentring automatically when `overflow` is set |
| rdData | output | 4 | Word delivered to the serializer on `rdClk` |
| overflow | output | 1 | Sticky collision flag in the `rdClk` domain |

## Verification
The bench builds the block with its default parameters: depth 9, two synchroniser stages, a read lead of 2 and a settle time of 8. With these values, a stall of one write period stays inside the margin, while a stall of eight periods or a burst of ten extra words crosses a collision threshold. A recovery then completes within a few tens of read cycles. Both clocks share one period. Stalls and bursts are chosen so that the write clock comes back at its original phase, and the contiguity and lead checks are taken against that restored phase.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

  // read-domain control state
  typedef enum logic {
    ST_CENTRE = 1'b0,
    ST_RUN    = 1'b1
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic zeroOut;   // force read data to zero
    logic realign;   // place read pointer behind synchronised write pointer
  } ctrlStrb_t;

  // collision indications from datapath to control (read domain)
  typedef struct packed {
    logic underrun;  // reader reached unwritten data
    logic overrun;   // writer caught up with reader (synchronised)
  } dpFlags_t;

endpackage

// File: rtl/efifo_sync.sv
module efifo_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/efifo_dp.sv
module efifo_dp
  import efifo_pkg::*;
#(
  parameter int DEPTH       = 9,
  parameter int DW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD        = 2
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  ctrlStrb_t     strb,
  output dpFlags_t      flags,
  output logic [DW-1:0] rdData
);

  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int MOD = 2 * DEPTH;
  // centre the pointer range in the Gray space so the wrap is a single-bit step
  localparam int OFF = (1 << (PW - 1)) - DEPTH;

  typedef logic [PW-1:0] ptr_t;

  localparam ptr_t GRAY_ZERO = ptr_t'(OFF) ^ (ptr_t'(OFF) >> 1);

  function automatic ptr_t ptrInc(ptr_t p);
    return (p == ptr_t'(MOD - 1)) ? '0 : ptr_t'(p + 1'b1);
  endfunction

  // (a - b) modulo MOD
  function automatic ptr_t ptrDist(ptr_t a, ptr_t b);
    return (a >= b) ? ptr_t'(a - b) : ptr_t'(a + ptr_t'(MOD) - b);
  endfunction

  function automatic ptr_t toGray(ptr_t b);
    ptr_t t;
    t = ptr_t'(b + ptr_t'(OFF));
    return t ^ (t >> 1);
  endfunction

  function automatic ptr_t fromGray(ptr_t g);
    ptr_t t;
    t[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) t[i] = t[i+1] ^ g[i];
    return ptr_t'(t - ptr_t'(OFF));
  endfunction

  function automatic logic [AW-1:0] toAddr(ptr_t p);
    return (p >= ptr_t'(DEPTH)) ? AW'(p - ptr_t'(DEPTH)) : AW'(p);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  ptr_t wrBin, wrGray, rdGrayW, rdBinW, wrFill;
  logic overrunW;

  efifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(GRAY_ZERO)) u_rdPtrSync (
    .clk(wrClk), .rstN(wrRstN), .din(rdGray), .dout(rdGrayW)
  );

  assign rdBinW = fromGray(rdGrayW);
  assign wrFill = ptrDist(wrBin, rdBinW);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin    <= '0;
      wrGray   <= GRAY_ZERO;
      overrunW <= 1'b0;
    end else begin
      wrBin    <= ptrInc(wrBin);
      wrGray   <= toGray(ptrInc(wrBin));
      overrunW <= (wrFill >= ptr_t'(DEPTH));
    end
  end

  always_ff @(posedge wrClk) begin
    mem[toAddr(wrBin)] <= wrData;
  end

  // R1: the pointer sent across domains moves one Gray bit per write
  p_gray_step_r1: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $past(wrRstN) |-> $countones(wrGray ^ $past(wrGray)) == 1);

  // ---------------- read domain ----------------
  ptr_t rdBin, rdGray, wrGrayR, wrBinR, rdFill, rdBinNext;
  logic overrunR;

  efifo_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(GRAY_ZERO)) u_wrPtrSync (
    .clk(rdClk), .rstN(rdRstN), .din(wrGray), .dout(wrGrayR)
  );

  efifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_overrunSync (
    .clk(rdClk), .rstN(rdRstN), .din(overrunW), .dout(overrunR)
  );

  assign wrBinR    = fromGray(wrGrayR);
  assign rdFill    = ptrDist(wrBinR, rdBin);
  assign rdBinNext = strb.realign ? ptrDist(wrBinR, ptr_t'(LEAD)) : ptrInc(rdBin);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= GRAY_ZERO;
      rdData <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
      rdData <= strb.zeroOut ? '0 : mem[toAddr(rdBin)];
    end
  end

  assign flags.underrun = (rdFill == '0) || (rdFill > ptr_t'(DEPTH));
  assign flags.overrun  = overrunR;

  // R7: zero output while the control holds the buffer in recentring
  p_zero_out_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strb.zeroOut |=> rdData == '0);

endmodule

// File: rtl/efifo_ctrl.sv
module efifo_ctrl
  import efifo_pkg::*;
#(
  parameter int SETTLE      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      rdClk,
  input  logic      rdRstN,
  input  logic      fifoRst,
  input  logic      autoRst,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      overflow
);

  localparam int CW = $clog2(SETTLE + 1);

  logic           rstReq;
  rdState_t       state;
  logic [CW-1:0]  settleCnt;

  efifo_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rstSync (
    .clk(rdClk), .rstN(rdRstN), .din(fifoRst), .dout(rstReq)
  );

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      state     <= ST_CENTRE;
      settleCnt <= '0;
      overflow  <= 1'b0;
    end else begin
      unique case (state)
        ST_CENTRE: begin
          if (rstReq) begin
            settleCnt <= '0;
          end else if (settleCnt == CW'(SETTLE - 1)) begin
            state     <= ST_RUN;
            settleCnt <= '0;
            overflow  <= 1'b0;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (flags.underrun || flags.overrun) overflow <= 1'b1;
          if (rstReq || (autoRst && overflow)) begin
            state     <= ST_CENTRE;
            settleCnt <= '0;
          end
        end
        default: state <= ST_CENTRE;
      endcase
    end
  end

  assign strb.zeroOut = (state == ST_CENTRE);
  assign strb.realign = (state == ST_CENTRE);

  p_ovf_set_r3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (state == ST_RUN) && flags.underrun |=> overflow);

  p_ovf_hold_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (state == ST_RUN) && overflow |=> overflow);

  p_auto_recentre_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (state == ST_RUN) && autoRst && overflow |=> state == ST_CENTRE);

  p_manual_recentre_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rstReq |=> state == ST_CENTRE);

  p_ovf_clear_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (state == ST_RUN) && ($past(state) == ST_CENTRE) |-> !overflow);

endmodule

// File: rtl/elastic_tx_fifo.sv
module elastic_tx_fifo
  import efifo_pkg::*;
#(
  parameter int DEPTH       = 9,
  parameter int DW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD        = 2,
  parameter int SETTLE      = 8
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          fifoRst,
  input  logic          autoRst,
  output logic [DW-1:0] rdData,
  output logic          overflow
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  efifo_dp #(
    .DEPTH(DEPTH), .DW(DW), .SYNC_STAGES(SYNC_STAGES), .LEAD(LEAD)
  ) u_dp (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN),
    .strb(strb), .flags(flags), .rdData(rdData)
  );

  efifo_ctrl #(
    .SETTLE(SETTLE), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .rdClk(rdClk), .rdRstN(rdRstN), .fifoRst(fifoRst), .autoRst(autoRst),
    .flags(flags), .strb(strb), .overflow(overflow)
  );

endmodule

// File: tb/elastic_tx_fifo_bench.sv
module elastic_tx_fifo_bench;

  logic       wrClk, wrRstN, rdClk, rdRstN, fifoRst, autoRst, overflow;
  logic [3:0] wrData, rdData;

  elastic_tx_fifo u_elastic_tx_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .fifoRst(fifoRst), .autoRst(autoRst),
    .rdData(rdData), .overflow(overflow)
  );

  // stimulus table: kind 1 = write clock stall, 2 = double-speed write burst
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] len;
    logic       autoOn;
    logic       expOvf;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'd1,  1'b0, 1'b0},
    '{2'd1, 8'd1,  1'b1, 1'b0},
    '{2'd1, 8'd8,  1'b0, 1'b1},
    '{2'd1, 8'd8,  1'b1, 1'b1},
    '{2'd2, 8'd20, 1'b1, 1'b1},
    '{2'd2, 8'd20, 1'b0, 1'b1}
  };

  int   nChk = 0, nBad = 0;
  int   stallReq = 0, fastReq = 0;
  int   wrCnt = 0;
  int   contErr = 0;
  logic chkOn = 0, chkFirst = 0, sawOvf = 0;
  logic [3:0] prevData = '0;

  // 125 MHz on both sides, read edges 2 ns after write edges
  initial begin
    wrClk = 0;
    forever begin
      if (stallReq > 0) begin
        #8; stallReq--;
      end else if (fastReq > 0) begin
        #2 wrClk = 1; #2 wrClk = 0; fastReq--;
      end else begin
        #4 wrClk = 1; #4 wrClk = 0;
      end
    end
  end

  initial begin
    rdClk = 0;
    #6 rdClk = 1;
    forever #4 rdClk = ~rdClk;
  end

  always @(negedge wrClk) wrCnt = wrCnt + 1;
  assign wrData = wrCnt[3:0];

  always @(negedge rdClk) begin
    if (overflow) sawOvf = 1;
    if (chkOn) begin
      if (!chkFirst && rdData != prevData + 4'd1) contErr++;
      prevData = rdData;
      chkFirst = 0;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitRd(input int n);
    repeat (n) @(posedge rdClk);
    #1;
  endtask

  task automatic armChk();
    contErr  = 0;
    chkFirst = 1;
    chkOn    = 1;
  endtask

  task automatic checkLead(input string tag);
    int lead;
    @(negedge rdClk);
    lead = int'((wrData - rdData) & 4'hF);
    check(lead >= 2 && lead <= 7, tag, lead, 4);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #1_500_000;
    nBad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int zeroBad;
    wrRstN = 0; rdRstN = 0; fifoRst = 0; autoRst = 0;
    repeat (5) @(posedge rdClk);
    #1 wrRstN = 1; rdRstN = 1;
    @(negedge rdClk); @(negedge rdClk);
    check(rdData == 4'd0, "R7 reset read data", rdData, 0);
    check(overflow == 1'b0, "R7 reset overflow", overflow, 0);

    waitRd(30);
    check(overflow == 1'b0, "R7 overflow low after initial recentring", overflow, 0);
    checkLead("R8 lead after power-up recentring");
    waitRd(1);
    armChk(); waitRd(30);
    check(contErr == 0, "R1 contiguous steady stream", contErr, 0);
    chkOn = 0;

    for (int v = 0; v < NV; v++) begin
      waitRd(1);
      autoRst = VEC[v].autoOn;
      sawOvf  = 0;
      if (!VEC[v].expOvf) armChk(); else chkOn = 0;
      if (VEC[v].kind == 2'd1) stallReq = int'(VEC[v].len);
      else                      fastReq  = int'(VEC[v].len);
      waitRd(60);
      if (!VEC[v].expOvf) begin
        check(sawOvf == 1'b0, $sformatf("R2 no overflow on short stall v%0d", v), sawOvf, 0);
        check(contErr == 0, $sformatf("R2 contiguous across short stall v%0d", v), contErr, 0);
      end else begin
        check(sawOvf == 1'b1, $sformatf("R3 collision flagged v%0d", v), sawOvf, 1);
        if (VEC[v].autoOn) begin
          check(overflow == 1'b0, $sformatf("R5 auto recovery cleared flag v%0d", v), overflow, 0);
          armChk(); waitRd(20);
          check(contErr == 0, $sformatf("R5 contiguous after auto recovery v%0d", v), contErr, 0);
        end else begin
          check(overflow == 1'b1, $sformatf("R4 flag held without auto v%0d", v), overflow, 1);
          fifoRst = 1; waitRd(3); fifoRst = 0;
          waitRd(30);
          check(overflow == 1'b0, $sformatf("R6 manual recentring cleared flag v%0d", v), overflow, 0);
          armChk(); waitRd(20);
          check(contErr == 0, $sformatf("R1 contiguous after manual recentring v%0d", v), contErr, 0);
        end
      end
      chkOn = 0;
    end

    // long manual request: held in recentring, zeros throughout
    autoRst = 0;
    waitRd(1);
    fifoRst = 1;
    zeroBad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge rdClk);
      if (i >= 5 && rdData != 4'd0) zeroBad++;
    end
    check(zeroBad == 0, "R6 R7 zeros while request held", zeroBad, 0);
    waitRd(1);
    fifoRst = 0;
    waitRd(20);
    check(overflow == 1'b0, "R6 flag low after long request", overflow, 0);
    checkLead("R8 lead after manual recentring");
    waitRd(1);
    armChk(); waitRd(20);
    check(contErr == 0, "R1 contiguous after long request", contErr, 0);
    chkOn = 0;

    summary();
    $finish;
  end

endmodule